// File: doc/BRIEF.md
# Rotated-Display Pixel and Memory Clock Enable Generator

This block turns one base display clock enable into two derived enables: a pixel enable and a memory enable. It sits in a display controller that can show its picture rotated by a quarter turn. The base enable comes from a separate clock selector and has the landscape rate. A rotation-on input decides whether the rotated timing applies at all. A mode input chooses between two rotated variants. A two-bit divider select then sets how many base pulses make up one pixel period and one memory period.

In the default variant both derived enables run at the same divided rate. In the alternate variant the memory enable runs at twice the pixel rate, so that two memory accesses fit into each pixel period. Both enables are decoded from one shared phase counter that advances only on base pulses. This keeps every pixel pulse on top of a memory pulse. The counter restarts on any configuration change, so after a change the first base pulse again yields both pulses.

Top module: `rot_clk_en_gen`

## Requirements
- R1: After reset the captured configuration is rotation off, default variant, select 00. With all configuration inputs at 0, every base pulse from the first cycle after reset gives both a pixel and a memory pulse.
- R2: With rot_on = 0, pix_en and mem_en both equal base_en in every cycle that is not a change cycle, whatever alt_mode and div_sel are.
- R3: With rot_on = 1 and alt_mode = 0, select value n (00..11) gives one pixel pulse and one memory pulse every 2^n base pulses (1, 2, 4, 8).
- R4: With rot_on = 1 and alt_mode = 1, select 00 and select 01 both give a pixel pulse every 2 base pulses and a memory pulse on every base pulse.
- R5: With rot_on = 1 and alt_mode = 1, select 10 gives pixel every 4 and memory every 2 base pulses, and select 11 gives pixel every 8 and memory every 4.
- R6: Every cycle with pix_en high also has mem_en high.
- R7: pix_en and mem_en are single-cycle pulses that can be high only in a cycle where base_en is high.
- R8: A change cycle is a cycle in which {rot_on, alt_mode, div_sel} differs from its value in the previous cycle. In a change cycle both outputs are low and any base pulse is dropped. The next base pulse gives both a pixel and a memory pulse, and after that the spacing is the full period.
- R9: Cycles with base_en low do not advance the phase, so pulse spacing is counted in base pulses and not in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_en | input | 1 | Landscape-rate base clock enable |
| rot_on | input | 1 | 1 applies rotated timing, 0 passes base rate through |
| alt_mode | input | 1 | 0 default variant, 1 alternate variant (memory twice pixel rate) |
| div_sel | input | 2 | Divider select |
| pix_en | output | 1 | Pixel clock enable pulse |
| mem_en | output | 1 | Memory clock enable pulse |

## Verification
The hardest case to reach is phase alignment when base pulses are irregular and the configuration has just changed. A simple cycle count cannot tell whether the counter restarted, or whether idle cycles wrongly advanced the phase. The bench steps through all eight mode and select pairs with rotation on, and several selects with rotation off. Each step changes the configuration and checks that the change cycle stays silent. It then feeds 64 base pulses, with idle cycles inserted in one pass and not in the other. For every base pulse it checks the expected output against the pulse index modulo the pixel and memory periods.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    localparam int SEL_W = 2;
    localparam int CNT_W = (1 << SEL_W) - 1;   // largest divide is 2**CNT_W
    localparam int SH_W  = $clog2(CNT_W + 1);

    typedef struct packed {
        logic             rot;
        logic             alt;
        logic [SEL_W-1:0] sel;
    } cfg_t;

    typedef struct packed {
        cfg_t             cfg;
        logic [CNT_W-1:0] cnt;
    } phase_t;
endpackage

// File: rtl/rcg_ratio_map.sv
module rcg_ratio_map
    import rcg_pkg::*;
(
    input  cfg_t            cfg,
    output logic [SH_W-1:0] pix_sh,
    output logic [SH_W-1:0] mem_sh
);
    always_comb begin
        if (!cfg.rot) begin
            pix_sh = '0;
            mem_sh = '0;
        end else if (!cfg.alt) begin
            pix_sh = SH_W'(cfg.sel);
            mem_sh = SH_W'(cfg.sel);
        end else begin
            pix_sh = (cfg.sel == '0) ? SH_W'(1) : SH_W'(cfg.sel);
            mem_sh = pix_sh - SH_W'(1);
        end
    end
endmodule

// File: rtl/rcg_phase_cnt.sv
module rcg_phase_cnt
    import rcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  cfg_t             cfg_in,
    output cfg_t             cfg_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             chg
);
    phase_t st_d, st_q;

    assign chg   = (cfg_in != st_q.cfg);
    assign cfg_q = st_q.cfg;
    assign cnt_q = st_q.cnt;

    always_comb begin
        st_d     = st_q;
        st_d.cfg = cfg_in;
        if (chg)
            st_d.cnt = '0;
        else if (base_en)
            st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a configuration change restarts the phase
    p_restart_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (cnt_q == '0));

    // R9: idle cycles hold the phase
    p_idle_holds_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg && !base_en) |=> $stable(cnt_q));
endmodule

// File: rtl/rcg_pulse_dec.sv
module rcg_pulse_dec
    import rcg_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    input  logic [SH_W-1:0]  pix_sh,
    input  logic [SH_W-1:0]  mem_sh,
    input  logic             base_en,
    input  logic             chg,
    output logic             pix_en,
    output logic             mem_en
);
    logic [CNT_W-1:0] pix_mask, mem_mask;

    always_comb begin
        for (int i = 0; i < CNT_W; i++) begin
            pix_mask[i] = (i < int'(pix_sh));
            mem_mask[i] = (i < int'(mem_sh));
        end
        pix_en = base_en && !chg && ((cnt & pix_mask) == '0);
        mem_en = base_en && !chg && ((cnt & mem_mask) == '0);
    end
endmodule

// File: rtl/rot_clk_en_gen.sv
module rot_clk_en_gen
    import rcg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_en,
    input  logic             rot_on,
    input  logic             alt_mode,
    input  logic [SEL_W-1:0] div_sel,
    output logic             pix_en,
    output logic             mem_en
);
    cfg_t             cfg_in, cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             chg;
    logic [SH_W-1:0]  pix_sh, mem_sh;

    assign cfg_in = '{rot: rot_on, alt: alt_mode, sel: div_sel};

    rcg_phase_cnt u_cnt (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .cfg_in(cfg_in),
        .cfg_q(cfg_q), .cnt_q(cnt_q), .chg(chg)
    );

    rcg_ratio_map u_map (
        .cfg(cfg_q), .pix_sh(pix_sh), .mem_sh(mem_sh)
    );

    rcg_pulse_dec u_dec (
        .cnt(cnt_q), .pix_sh(pix_sh), .mem_sh(mem_sh), .base_en(base_en),
        .chg(chg), .pix_en(pix_en), .mem_en(mem_en)
    );

    p_pix_on_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en |-> mem_en);

    p_pulse_needs_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en || mem_en) |-> base_en);

    p_quiet_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (!pix_en && !mem_en));

    p_passthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rot_on && !cfg_q.rot && !chg) |-> (pix_en == base_en && mem_en == base_en));
endmodule

// File: tb/sim_rot_clk_en_gen.sv
module sim_rot_clk_en_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_en = 1'b0;
    logic       rot_on = 1'b0;
    logic       alt_mode = 1'b0;
    logic [1:0] div_sel = 2'b00;
    logic       pix_en, mem_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rot_clk_en_gen u0 (
        .clk(clk), .rst_n(rst_n), .base_en(base_en), .rot_on(rot_on),
        .alt_mode(alt_mode), .div_sel(div_sel), .pix_en(pix_en), .mem_en(mem_en)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_combo(input bit r, input bit a, input logic [1:0] s,
                             input bit gaps, input string req);
        int pdiv, mdiv, bad_pat, bad_r6, bad_r7, npix, nmem;
        if (!r) begin pdiv = 1; mdiv = 1; end
        else if (!a) begin pdiv = 1 << s; mdiv = pdiv; end
        else begin pdiv = (s == 2'b00) ? 2 : (1 << s); mdiv = pdiv / 2; end
        bad_pat = 0; bad_r6 = 0; bad_r7 = 0; npix = 0; nmem = 0;
        // change cycle: base pulse offered, must be dropped (R8)
        @(negedge clk);
        rot_on = r; alt_mode = a; div_sel = s; base_en = 1'b1;
        #1;
        check("R8 change cycle silent", int'(pix_en) + int'(mem_en), 0);
        for (int k = 0; k < 64; k++) begin
            if (gaps && (k % 3 == 1)) begin
                @(negedge clk); base_en = 1'b0; #1;
                if (pix_en || mem_en) bad_r7++;
            end
            @(negedge clk); base_en = 1'b1; #1;
            if (k == 0)
                check("R8 first pulse after change", int'(pix_en) + int'(mem_en), 2);
            if (pix_en != ((k % pdiv) == 0)) bad_pat++;
            if (mem_en != ((k % mdiv) == 0)) bad_pat++;
            if (pix_en && !mem_en) bad_r6++;
            npix += int'(pix_en); nmem += int'(mem_en);
        end
        @(negedge clk); base_en = 1'b0;
        check({req, " pattern mismatches"}, bad_pat, 0);
        check({req, " pixel count"}, npix, 64 / pdiv);
        check({req, " memory count"}, nmem, 64 / mdiv);
        check("R6 pixel without memory", bad_r6, 0);
        if (gaps) begin
            check("R7 pulse in idle cycle", bad_r7, 0);
            check("R9 phase under gaps", bad_pat, 0);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset outputs low", int'(pix_en) + int'(mem_en), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); base_en = 1'b1; #1;
        check("R1 first base pulse after reset", int'(pix_en) + int'(mem_en), 2);
        @(negedge clk); base_en = 1'b0; #1;
        check("R7 low without base", int'(pix_en) + int'(mem_en), 0);

        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 4; s++)
                run_combo(1'b1, 1'b0, 2'(s), g[0], "R3 default");
            run_combo(1'b1, 1'b1, 2'b00, g[0], "R4 alt sel00");
            run_combo(1'b1, 1'b1, 2'b01, g[0], "R4 alt sel01");
            run_combo(1'b1, 1'b1, 2'b10, g[0], "R5 alt sel10");
            run_combo(1'b1, 1'b1, 2'b11, g[0], "R5 alt sel11");
            run_combo(1'b0, 1'b1, 2'b11, g[0], "R2 rotation off alt");
            run_combo(1'b0, 1'b0, 2'b10, g[0], "R2 rotation off default");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule